// File: doc/BRIEF.md
# Vectored Interrupt Source Controller

This block holds the interrupt state of three requesters that share one daisy-chained interrupt line: a first parallel port, the counter/timer group and a second parallel port. The logic that owns those functions reaches this block only through one request pulse per source and a few status lines per source. Each source keeps four flags: pending, enabled, in service and an error flag. Software changes the first three by writing a 3-bit command into the source's command/status register.

A master control register sets the global behaviour. One bit allows or blocks all requests. One bit cuts the chain below this block. One bit stops the block from driving a vector on acknowledge. Three bits, one per source, choose whether that source's vector carries its status lines. One bit holds the whole interrupt state in reset. The block drives an active-low request, takes the enable from the chain above it and drives the enable for the chain below. On an acknowledge it marks the winning source as in service and presents that source's vector in the same cycle.

Top module: `irq_vec_ctl`

## Requirements
- R1: After hardware reset the master register reads 0x01, every command/status and vector register reads 0x00, `irq_n` is high, `vec_drive` is low and `chain_out` equals `chain_in`.
- R2: While master bit 0 is set, all source flags read 0 one cycle later. Writes to addresses 1 to 6 and request pulses are ignored during that time.
- R3: A write to a command/status register (addresses 1, 2 and 3 for first port, counter/timers and second port) applies the command in bits 7:5: 0 no action, 1 clear pending and in-service, 2 set in-service, 3 clear in-service, 4 set pending, 5 clear pending, 6 set enable, 7 clear enable. The register reads back with in-service in bit 7, enable in bit 6, pending in bit 5, error in bit 4 and zeros below.
- R4: A request pulse (`src_req` bit 0 first port, bit 1 counter/timers, bit 2 second port) sets pending. A pulse that arrives while pending is already set also sets the error flag. Commands 1 and 5 clear the error flag, and bit 4 of a write has no effect on it.
- R5: `irq_n` is low only when some source has pending and enable set, in-service clear, `chain_in` high, master bit 7 set, and no higher-priority source in service. Priority runs first port, then counter/timers, then second port.
- R6: With master bit 7 clear, `irq_n` stays high whatever the source flags are.
- R7: `chain_out` is high only when `chain_in` is high, master bit 6 is clear, and no source is either in service or both pending and enabled.
- R8: When `iack` is high in a cycle where some source requests, the highest-priority requesting source becomes in service at the next edge. In that cycle `vec_drive` is high and `vec_out` carries that source's vector register (addresses 4, 5 and 6). With no requester, `vec_drive` stays low and no flag changes.
- R9: With master bit 5 set, `vec_drive` stays low on acknowledge, but the winning source still becomes in service.
- R10: When a source's status-include bit is set (master bit 4 first port, bit 3 second port, bit 2 counter/timers), bits 3:1 of its returned vector are replaced by its 3 `src_stat` lines. The first port uses `src_stat` bits 2:0, the counter/timers bits 5:3 and the second port bits 8:6.
- R11: A source in service blocks requests from lower-priority sources only. A higher-priority source can still request while a lower one is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| src_req | input | 3 | One-cycle request pulses, one per source |
| src_stat | input | 9 | Status lines, 3 per source |
| chain_in | input | 1 | Enable from the chain above |
| chain_out | output | 1 | Enable to the chain below |
| irq_n | output | 1 | Active-low interrupt request |
| iack | input | 1 | Interrupt acknowledge, one cycle |
| vec_out | output | 8 | Returned vector, zero when not driven |
| vec_drive | output | 1 | Vector valid during acknowledge |

## Verification
A wrong flag in any source shows on the ports within one cycle. It appears in the read-back byte of that source. It also changes `irq_n` or `chain_out`, because both are combinational functions of the flags. A wrong priority or a wrong in-service update is seen at the acknowledge itself, through `vec_out`, and again at the following edge through the request line of the lower sources. A fault in vector composition is seen only during acknowledge cycles. The bench therefore acknowledges under each status-include setting and under each source.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_CLR_IP_IUS = 3'd1,
    CMD_SET_IUS    = 3'd2,
    CMD_CLR_IUS    = 3'd3,
    CMD_SET_IP     = 3'd4,
    CMD_CLR_IP     = 3'd5,
    CMD_SET_IE     = 3'd6,
    CMD_CLR_IE     = 3'd7
  } irq_cmd_e;

  typedef struct packed {
    logic ius;
    logic ie;
    logic ip;
    logic err;
  } src_flags_t;

  // master control bit positions
  localparam int MC_MIE   = 7;
  localparam int MC_DLC   = 6;
  localparam int MC_NOVEC = 5;
  localparam int MC_RST   = 0;

  // status-include bit in the master register for a source index
  function automatic int stat_inc_bit(input int idx);
    case (idx)
      0:       return 4;
      1:       return 2;
      default: return 3;
    endcase
  endfunction

  // next flag state: command first, then request pulse, then grant
  function automatic src_flags_t flags_next(input src_flags_t cur,
                                            input logic cmd_we,
                                            input irq_cmd_e cmd,
                                            input logic req,
                                            input logic grant);
    src_flags_t n;
    n = cur;
    if (cmd_we) begin
      case (cmd)
        CMD_CLR_IP_IUS: begin n.ip = 1'b0; n.ius = 1'b0; n.err = 1'b0; end
        CMD_SET_IUS:    n.ius = 1'b1;
        CMD_CLR_IUS:    n.ius = 1'b0;
        CMD_SET_IP:     n.ip = 1'b1;
        CMD_CLR_IP:     begin n.ip = 1'b0; n.err = 1'b0; end
        CMD_SET_IE:     n.ie = 1'b1;
        CMD_CLR_IE:     n.ie = 1'b0;
        default:        ;
      endcase
    end
    if (req) begin
      if (cur.ip) n.err = 1'b1;
      n.ip = 1'b1;
    end
    if (grant) n.ius = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       cmd_we,
  input  irq_cmd_e   cmd,
  input  logic       req,
  input  logic       grant,
  output src_flags_t flags
);

  src_flags_t flags_q;
  src_flags_t flags_d;

  always_comb begin
    flags_d = flags_next(flags_q, cmd_we, cmd, req, grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (hold) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/irq_chain_arb.sv
module irq_chain_arb #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] ip,
  input  logic [NSRC-1:0] ie,
  input  logic [NSRC-1:0] ius,
  input  logic            mie,
  input  logic            dlc,
  input  logic            chain_in,
  input  logic            iack,
  output logic [NSRC-1:0] req_ok,
  output logic [NSRC-1:0] win,
  output logic [NSRC-1:0] grant,
  output logic            irq_n,
  output logic            chain_out
);

  logic [NSRC-1:0] higher_busy;
  logic            any_busy;

  assign higher_busy[0] = 1'b0;

  for (genvar k = 1; k < NSRC; k++) begin : g_blk
    assign higher_busy[k] = higher_busy[k-1] | ius[k-1];
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_req
    assign req_ok[k] = ip[k] & ie[k] & ~ius[k] & mie & chain_in & ~higher_busy[k];
  end

  always_comb begin
    logic found;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (req_ok[k] && !found) begin
        win[k] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign grant     = iack ? win : '0;
  assign irq_n     = ~|req_ok;
  assign any_busy  = |((ip & ie) | ius);
  assign chain_out = chain_in & ~dlc & ~any_busy;

endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int STAT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [2:0]           src_req,
  input  logic [3*STAT_W-1:0]  src_stat,
  input  logic                 chain_in,
  output logic                 chain_out,
  output logic                 irq_n,
  input  logic                 iack,
  output logic [DATA_W-1:0]    vec_out,
  output logic                 vec_drive
);

  localparam int NSRC     = 3;
  localparam int CS_BASE  = 1;
  localparam int VEC_BASE = CS_BASE + NSRC;
  localparam int CMD_LSB  = DATA_W - 3;
  localparam logic [DATA_W-1:0] MC_RESET_VAL = DATA_W'(1);

  logic [DATA_W-1:0] mcr_q;
  logic [DATA_W-1:0] vec_q [NSRC];
  src_flags_t        flags [NSRC];
  logic [NSRC-1:0]   ip_v, ie_v, ius_v, err_v;
  logic [NSRC-1:0]   cmd_we_v, stat_inc;
  logic [NSRC-1:0]   req_ok, win, grant;
  logic              hold, mie, dlc, novec, ack_hit;
  irq_cmd_e          cmd_code;

  // named internal events for the checker
  assign hold     = mcr_q[MC_RST];
  assign mie      = mcr_q[MC_MIE];
  assign dlc      = mcr_q[MC_DLC];
  assign novec    = mcr_q[MC_NOVEC];
  assign cmd_code = irq_cmd_e'(bus_wdata[DATA_W-1:CMD_LSB]);

  function automatic logic [DATA_W-1:0] vec_compose(input logic [DATA_W-1:0] base,
                                                    input logic [STAT_W-1:0] st,
                                                    input logic inc);
    logic [DATA_W-1:0] r;
    r = base;
    if (inc) r[STAT_W:1] = st;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= MC_RESET_VAL;
    end else if (bus_we && bus_addr == '0) begin
      mcr_q <= bus_wdata;
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam int SB = stat_inc_bit(k);

    assign cmd_we_v[k] = bus_we && !hold && (bus_addr == ADDR_W'(CS_BASE + k));
    assign stat_inc[k] = mcr_q[SB];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[k] <= '0;
      end else if (bus_we && !hold && bus_addr == ADDR_W'(VEC_BASE + k)) begin
        vec_q[k] <= bus_wdata;
      end
    end

    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .cmd_we (cmd_we_v[k]),
      .cmd    (cmd_code),
      .req    (src_req[k]),
      .grant  (grant[k]),
      .flags  (flags[k])
    );

    assign ip_v[k]  = flags[k].ip;
    assign ie_v[k]  = flags[k].ie;
    assign ius_v[k] = flags[k].ius;
    assign err_v[k] = flags[k].err;
  end

  irq_chain_arb #(.NSRC(NSRC)) u_arb (
    .ip        (ip_v),
    .ie        (ie_v),
    .ius       (ius_v),
    .mie       (mie),
    .dlc       (dlc),
    .chain_in  (chain_in),
    .iack      (iack),
    .req_ok    (req_ok),
    .win       (win),
    .grant     (grant),
    .irq_n     (irq_n),
    .chain_out (chain_out)
  );

  assign ack_hit   = iack & (|win);
  assign vec_drive = ack_hit & ~novec;

  always_comb begin
    vec_out = '0;
    if (vec_drive) begin
      for (int k = 0; k < NSRC; k++) begin
        if (win[k]) vec_out = vec_compose(vec_q[k], src_stat[k*STAT_W +: STAT_W], stat_inc[k]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = mcr_q;
    for (int k = 0; k < NSRC; k++) begin
      if (bus_addr == ADDR_W'(CS_BASE + k))
        bus_rdata = {ius_v[k], ie_v[k], ip_v[k], err_v[k], {(DATA_W-4){1'b0}}};
      if (bus_addr == ADDR_W'(VEC_BASE + k))
        bus_rdata = vec_q[k];
    end
  end

endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mcr,
  input logic       irq_n,
  input logic       chain_in,
  input logic       chain_out,
  input logic       iack,
  input logic       vec_drive,
  input logic [2:0] win,
  input logic [2:0] ip,
  input logic [2:0] ie,
  input logic [2:0] ius,
  input logic [2:0] err
);

  p_mie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr[7] |-> irq_n);

  p_dlc_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[6] |-> !chain_out);

  p_chain_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in |-> !chain_out);

  p_novec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[5] |-> !vec_drive);

  p_single_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  p_ack_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && (|win)) |=> ((ius & $past(win)) == $past(win)));

  p_hold_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[0] |=> ((ip | ie | ius | err) == 3'b000));

  p_top_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ius[0] |-> (win[2:1] == 2'b00));

endmodule

bind irq_vec_ctl irq_vec_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mcr       (mcr_q),
  .irq_n     (irq_n),
  .chain_in  (chain_in),
  .chain_out (chain_out),
  .iack      (iack),
  .vec_drive (vec_drive),
  .win       (win),
  .ip        (ip_v),
  .ie        (ie_v),
  .ius       (ius_v),
  .err       (err_v)
);

// File: tb/irq_vec_ctl_tb_top.sv
module irq_vec_ctl_tb_top;

  localparam int SEL_RD  = 0;
  localparam int SEL_IRQ = 1;
  localparam int SEL_CHN = 2;
  localparam int SEL_OE  = 3;
  localparam int SEL_VEC = 4;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] src_req = '0;
  logic [8:0] src_stat = {3'b110, 3'b011, 3'b101};
  logic       chain_in = 1'b1;
  logic       chain_out, irq_n;
  logic       iack = 1'b0;
  logic [7:0] vec_out;
  logic       vec_drive;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;
  item_t sb_q[$];
  item_t it;

  always #4 clk = ~clk;

  irq_vec_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
    .src_stat(src_stat), .chain_in(chain_in), .chain_out(chain_out),
    .irq_n(irq_n), .iack(iack), .vec_out(vec_out), .vec_drive(vec_drive)
  );

  // monitor: pop expected items and compare at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        SEL_RD:  act = bus_rdata;
        SEL_IRQ: act = {7'd0, irq_n};
        SEL_CHN: act = {7'd0, chain_out};
        SEL_OE:  act = {7'd0, vec_drive};
        default: act = vec_out;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [7:0] exp, input string tag);
    item_t x;
    x.sel = sel; x.exp = exp; x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] r);
    @(posedge clk); #1;
    src_req = r;
    @(posedge clk); #1;
    src_req = '0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    push(SEL_RD, exp, tag);
    settle();
  endtask

  task automatic chk_pin(input int sel, input logic [7:0] exp, input string tag);
    push(sel, exp, tag);
    settle();
  endtask

  task automatic ack(input logic oe, input logic [7:0] v, input string tag);
    @(posedge clk); #1;
    iack = 1'b1;
    push(SEL_OE, {7'd0, oe}, tag);
    push(SEL_VEC, v, tag);
    settle();
    @(posedge clk); #1;
    iack = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_rd(3'd0, 8'h01, "R1 master");
    chk_rd(3'd1, 8'h00, "R1 cs first");
    chk_rd(3'd6, 8'h00, "R1 vec second");
    chk_pin(SEL_IRQ, 8'h01, "R1 irq_n");
    chk_pin(SEL_CHN, 8'h01, "R1 chain_out");
    chk_pin(SEL_OE,  8'h00, "R1 vec_drive");

    // R2 held in reset: writes and pulses ignored
    wr(3'd4, 8'h40);
    chk_rd(3'd4, 8'h00, "R2 vec write ignored");
    wr(3'd1, 8'h80);
    pulse(3'b001);
    chk_rd(3'd1, 8'h00, "R2 cs ignored");

    wr(3'd0, 8'h00);
    wr(3'd4, 8'hA0);
    wr(3'd5, 8'h50);
    wr(3'd6, 8'h30);
    chk_rd(3'd4, 8'hA0, "R8 vec reg first");

    // R3 command codes on second port
    wr(3'd3, 8'hC0); chk_rd(3'd3, 8'h40, "R3 set IE");
    wr(3'd3, 8'h80); chk_rd(3'd3, 8'h60, "R3 set IP");
    chk_pin(SEL_IRQ, 8'h01, "R6 mie off");
    chk_pin(SEL_CHN, 8'h00, "R7 pending blocks chain");
    wr(3'd3, 8'h40); chk_rd(3'd3, 8'hE0, "R3 set IUS");
    wr(3'd3, 8'h60); chk_rd(3'd3, 8'h60, "R3 clr IUS");
    wr(3'd3, 8'hA0); chk_rd(3'd3, 8'h40, "R3 clr IP");
    wr(3'd3, 8'hE0); chk_rd(3'd3, 8'h00, "R3 clr IE");
    wr(3'd3, 8'h80); wr(3'd3, 8'h40);
    chk_rd(3'd3, 8'hA0, "R3 IP and IUS");
    wr(3'd3, 8'h20); chk_rd(3'd3, 8'h00, "R3 clr IP IUS");
    wr(3'd3, 8'h1F); chk_rd(3'd3, 8'h00, "R4 nop ignores low bits");
    chk_pin(SEL_CHN, 8'h01, "R7 idle chain");

    // R4 error flag
    pulse(3'b001); chk_rd(3'd1, 8'h20, "R4 pulse sets IP");
    pulse(3'b001); chk_rd(3'd1, 8'h30, "R4 second pulse sets ERR");
    wr(3'd1, 8'hA0); chk_rd(3'd1, 8'h00, "R4 clr IP clears ERR");
    pulse(3'b100); pulse(3'b100);
    chk_rd(3'd3, 8'h30, "R4 err on second port");
    wr(3'd3, 8'h20); chk_rd(3'd3, 8'h00, "R4 cmd1 clears ERR");

    // R5 / R6 request line
    wr(3'd1, 8'hC0); pulse(3'b001);
    chk_rd(3'd1, 8'h60, "R5 first pending");
    chk_pin(SEL_IRQ, 8'h01, "R6 mie clear");
    wr(3'd0, 8'h80);
    chk_pin(SEL_IRQ, 8'h00, "R5 request");
    chk_pin(SEL_CHN, 8'h00, "R7 busy");
    @(posedge clk); #1 chain_in = 1'b0;
    chk_pin(SEL_IRQ, 8'h01, "R5 chain_in low");
    chk_pin(SEL_CHN, 8'h00, "R7 chain_in low");
    @(posedge clk); #1 chain_in = 1'b1;

    // R8 / R11 acknowledge and priority
    wr(3'd2, 8'hC0); pulse(3'b010);
    ack(1'b1, 8'hA0, "R8 first port wins");
    chk_rd(3'd1, 8'hE0, "R8 IUS set");
    chk_pin(SEL_IRQ, 8'h01, "R11 lower blocked");
    wr(3'd1, 8'h20);
    chk_pin(SEL_IRQ, 8'h00, "R5 counter requests");
    ack(1'b1, 8'h50, "R8 counter vector");
    chk_rd(3'd2, 8'hE0, "R8 counter IUS");
    pulse(3'b001);
    chk_pin(SEL_IRQ, 8'h00, "R11 higher not blocked");
    ack(1'b1, 8'hA0, "R11 higher acked");
    wr(3'd1, 8'h20); wr(3'd2, 8'h20);
    ack(1'b0, 8'h00, "R8 no requester");
    chk_rd(3'd1, 8'h40, "R8 no change");

    // R9 no vector
    wr(3'd0, 8'hA0);
    wr(3'd3, 8'hC0); pulse(3'b100);
    chk_pin(SEL_IRQ, 8'h00, "R9 request");
    ack(1'b0, 8'h00, "R9 vector suppressed");
    chk_rd(3'd3, 8'hE0, "R9 IUS still set");
    wr(3'd3, 8'h20);

    // R10 status inclusion
    wr(3'd0, 8'h88); pulse(3'b100);
    ack(1'b1, 8'h3C, "R10 second port status");
    wr(3'd3, 8'h20);
    wr(3'd0, 8'h90); pulse(3'b001);
    ack(1'b1, 8'hAA, "R10 first port status");
    wr(3'd1, 8'h20);
    pulse(3'b100);
    ack(1'b1, 8'h30, "R10 second port plain");
    wr(3'd3, 8'h20);
    wr(3'd0, 8'h84); pulse(3'b010);
    ack(1'b1, 8'h56, "R10 counter status");
    wr(3'd2, 8'h20);

    // R7 lower chain cut
    wr(3'd0, 8'hC0);
    chk_pin(SEL_CHN, 8'h00, "R7 cut");
    wr(3'd0, 8'h80);
    chk_pin(SEL_CHN, 8'h01, "R7 restored");

    // R2 reset bit re-entered
    pulse(3'b001);
    chk_pin(SEL_IRQ, 8'h00, "R2 before hold");
    wr(3'd0, 8'h81);
    chk_rd(3'd1, 8'h00, "R2 flags cleared");
    chk_pin(SEL_IRQ, 8'h01, "R2 irq released");
    wr(3'd0, 8'h80);
    chk_rd(3'd1, 8'h00, "R2 IE lost");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule